// File: doc/BRIEF.md
# Data-Processing Instruction Execute Unit

This unit carries out one 32-bit data-processing instruction for each start pulse. It decodes the instruction word and reads the base register and the register second operand through two combinational read ports of an external register file. It then computes one of sixteen logical or arithmetic operations. One cycle after the start pulse it presents a register write and an updated status word together with a done pulse.

The status word holds the negative, zero, carry and overflow flags in its top four bits. Its lowest bit reports an illegal instruction. An illegal word changes nothing except that bit, and no register is written for it. A legal word always clears that bit. Every status bit outside those five passes through unchanged.

Top module: `dpExecUnit`

## Requirements
- R1: A word is legal only when bits 31:26 are 111000 and the bits outside every field are zero. For I=1 those bits are 11:8. For I=0 they are 11:4. Any other word yields status bit 0 = 1.
- R2: For an illegal word, wrEn stays low and status bits 31:1 equal statusIn. For a legal word, status bit 0 is 0.
- R3: The second operand is the zero-extended imm8 in bits 7:0 when bit 25 (I) is 1. It is register bits 3:0 when I is 0. rdSelA is driven from bits 19:16 (Rn) and rdSelB from bits 3:0. The write select is bits 15:12 (Rd).
- R4: Bits 24:21 select the operation. The logical codes are 0000 and, 0001 eor, 1100 orr, 1101 mov, 1110 bic (Rn and not Op2) and 1111 mvn (not Op2).
- R5: The arithmetic codes are 0010 sub (Rn-Op2), 0011 rsb (Op2-Rn), 0100 add and 0101 adc.
- R6: adc adds the incoming C (status bit 29). sbc (0110) computes Rn-Op2-!C. rsc (0111) computes Op2-Rn-!C.
- R7: tst (1000), teq (1001), cmp (1010) and cmn (1011) never write a register. They always update the flags, whatever the value of S.
- R8: mov and mvn give a result that does not depend on the Rn register value.
- R9: When S (bit 20) is 1, N (bit 31) takes result bit 31 and Z (bit 30) is set when the result is zero. When S is 0, a non-compare operation leaves bits 31:28 unchanged.
- R10: An arithmetic operation with flag update sets C (bit 29) to the carry out, which is the inverted borrow for subtractions. It sets V (bit 28) to signed overflow.
- R11: A logical operation leaves C and V unchanged.
- R12: done is high exactly one cycle after a start pulse, and wrEn is high only with done. Status bits 27:1 always pass through from statusIn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to execute instrWord |
| instrWord | input | 32 | Instruction to execute, held during start |
| statusIn | input | 32 | Current status word, held during start |
| rdSelA | output | 4 | Register file read select for Rn |
| rdSelB | output | 4 | Register file read select for Rm |
| rdDataA | input | 32 | Read data for rdSelA |
| rdDataB | input | 32 | Read data for rdSelB |
| wrEn | output | 1 | Register file write enable |
| wrSel | output | 4 | Register file write select |
| wrData | output | 32 | Register file write data |
| statusOut | output | 32 | Updated status word |
| done | output | 1 | Result valid pulse |

## Verification
The read selects follow instrWord with no register in the path, so the bench checks them in the start cycle. The write enable, write select, write data, status word and done are all captured at the clock edge that samples start. They are therefore due in the cycle after start. The bench checks them at the falling edge that follows that clock edge, and one cycle later it confirms that done and wrEn have dropped again. Expected flags are worked out in the bench with 64-bit signed and unsigned arithmetic rather than a 33-bit adder.

// File: rtl/dpExecPkg.sv
package dpExecPkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } carrySel_e;

  typedef enum logic [2:0] {
    LOG_AND = 3'd0,
    LOG_EOR = 3'd1,
    LOG_ORR = 3'd2,
    LOG_MOV = 3'd3,
    LOG_BIC = 3'd4,
    LOG_MVN = 3'd5
  } logicSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      capture;
    logic      legal;
    logic      useImm;
    logic      arith;
    logic      invRn;
    logic      invOp2;
    carrySel_e carrySel;
    logicSel_e logicSel;
    logic      writeRd;
    logic      setNZ;
    logic      setCV;
  } dpStrobe_t;

  localparam logic [5:0] TOP_PATTERN = 6'b111000;

endpackage

// File: rtl/dpExecCtrl.sv
module dpExecCtrl
  import dpExecPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [5:0] topBits,
  input  logic       iBit,
  input  logic [3:0] opField,
  input  logic       sBit,
  input  logic [7:0] padBits,
  output dpStrobe_t  strobes,
  output logic       done
);

  logic   formatOk;
  logic   padOk;
  logic   legal;
  logic   isCompare;
  aluOp_e op;

  assign op       = aluOp_e'(opField);
  assign formatOk = (topBits == TOP_PATTERN);
  // Immediate form frees bits 7:4 for data, register form uses only 3:0
  assign padOk    = iBit ? (padBits[7:4] == 4'b0) : (padBits == 8'b0);
  assign legal    = formatOk && padOk;

  always_comb begin
    strobes          = '0;
    strobes.capture  = start;
    strobes.legal    = legal;
    strobes.useImm   = iBit;
    strobes.carrySel = CIN_ZERO;
    strobes.logicSel = LOG_AND;
    isCompare        = 1'b0;
    unique case (op)
      OP_AND: strobes.logicSel = LOG_AND;
      OP_EOR: strobes.logicSel = LOG_EOR;
      OP_ORR: strobes.logicSel = LOG_ORR;
      OP_MOV: strobes.logicSel = LOG_MOV;
      OP_BIC: strobes.logicSel = LOG_BIC;
      OP_MVN: strobes.logicSel = LOG_MVN;
      OP_TST: begin
        strobes.logicSel = LOG_AND;
        isCompare        = 1'b1;
      end
      OP_TEQ: begin
        strobes.logicSel = LOG_EOR;
        isCompare        = 1'b1;
      end
      OP_SUB: begin
        strobes.arith    = 1'b1;
        strobes.invOp2   = 1'b1;
        strobes.carrySel = CIN_ONE;
      end
      OP_RSB: begin
        strobes.arith    = 1'b1;
        strobes.invRn    = 1'b1;
        strobes.carrySel = CIN_ONE;
      end
      OP_ADD: begin
        strobes.arith    = 1'b1;
        strobes.carrySel = CIN_ZERO;
      end
      OP_ADC: begin
        strobes.arith    = 1'b1;
        strobes.carrySel = CIN_FLAG;
      end
      OP_SBC: begin
        strobes.arith    = 1'b1;
        strobes.invOp2   = 1'b1;
        strobes.carrySel = CIN_FLAG;
      end
      OP_RSC: begin
        strobes.arith    = 1'b1;
        strobes.invRn    = 1'b1;
        strobes.carrySel = CIN_FLAG;
      end
      OP_CMP: begin
        strobes.arith    = 1'b1;
        strobes.invOp2   = 1'b1;
        strobes.carrySel = CIN_ONE;
        isCompare        = 1'b1;
      end
      OP_CMN: begin
        strobes.arith    = 1'b1;
        strobes.carrySel = CIN_ZERO;
        isCompare        = 1'b1;
      end
      default: strobes.logicSel = LOG_AND;
    endcase
    strobes.writeRd = legal && !isCompare;
    strobes.setNZ   = legal && (sBit || isCompare);
    strobes.setCV   = legal && (sBit || isCompare) && strobes.arith;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done <= 1'b0;
    end else begin
      done <= start;
    end
  end

endmodule

// File: rtl/dpExecData.sv
module dpExecData
  import dpExecPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 4,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [IMM_W-1:0]  immField,
  input  logic [SEL_W-1:0]  rdField,
  input  logic [DATA_W-1:0] rnData,
  input  logic [DATA_W-1:0] rmData,
  input  logic [DATA_W-1:0] statusIn,
  output logic              wrEn,
  output logic [SEL_W-1:0]  wrSel,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusOut
);

  localparam int FLAG_N   = DATA_W - 1;
  localparam int FLAG_Z   = DATA_W - 2;
  localparam int FLAG_C   = DATA_W - 3;
  localparam int FLAG_V   = DATA_W - 4;
  localparam int FLAG_ILL = 0;

  logic [DATA_W-1:0] op2;
  logic [DATA_W-1:0] addA;
  logic [DATA_W-1:0] addB;
  logic              carryIn;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sumRes;
  logic              carryOut;
  logic              overflow;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] nextStatus;

  // Second operand: zero-extended immediate or register
  assign op2 = strobes.useImm ? {{(DATA_W-IMM_W){1'b0}}, immField} : rmData;

  // One adder serves all eight arithmetic codes via input inversion
  assign addA = strobes.invRn  ? ~rnData : rnData;
  assign addB = strobes.invOp2 ? ~op2    : op2;

  always_comb begin
    unique case (strobes.carrySel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = statusIn[FLAG_C];
      default:  carryIn = 1'b0;
    endcase
  end

  assign sumWide  = {1'b0, addA} + {1'b0, addB} + {{DATA_W{1'b0}}, carryIn};
  assign sumRes   = sumWide[DATA_W-1:0];
  assign carryOut = sumWide[DATA_W];
  assign overflow = (addA[DATA_W-1] == addB[DATA_W-1]) &&
                    (sumRes[DATA_W-1] != addA[DATA_W-1]);

  always_comb begin
    unique case (strobes.logicSel)
      LOG_EOR: logicRes = rnData ^ op2;
      LOG_ORR: logicRes = rnData | op2;
      LOG_MOV: logicRes = op2;
      LOG_BIC: logicRes = rnData & ~op2;
      LOG_MVN: logicRes = ~op2;
      default: logicRes = rnData & op2;
    endcase
  end

  assign result = strobes.arith ? sumRes : logicRes;

  always_comb begin
    nextStatus = statusIn;
    if (!strobes.legal) begin
      nextStatus[FLAG_ILL] = 1'b1;
    end else begin
      nextStatus[FLAG_ILL] = 1'b0;
      if (strobes.setNZ) begin
        nextStatus[FLAG_N] = result[DATA_W-1];
        nextStatus[FLAG_Z] = (result == '0);
      end
      if (strobes.setCV) begin
        nextStatus[FLAG_C] = carryOut;
        nextStatus[FLAG_V] = overflow;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn      <= 1'b0;
      wrSel     <= '0;
      wrData    <= '0;
      statusOut <= '0;
    end else if (strobes.capture) begin
      wrEn      <= strobes.writeRd;
      wrSel     <= rdField;
      wrData    <= result;
      statusOut <= nextStatus;
    end else begin
      wrEn      <= 1'b0;
    end
  end

endmodule

// File: rtl/dpExecUnit.sv
module dpExecUnit
  import dpExecPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       instrWord,
  input  logic [DATA_W-1:0] statusIn,
  output logic [3:0]        rdSelA,
  output logic [3:0]        rdSelB,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  output logic              wrEn,
  output logic [3:0]        wrSel,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusOut,
  output logic              done
);

  localparam int SEL_W = 4;
  localparam int IMM_W = 8;

  dpStrobe_t strobes;

  assign rdSelA = instrWord[19:16];
  assign rdSelB = instrWord[3:0];

  dpExecCtrl ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .topBits (instrWord[31:26]),
    .iBit    (instrWord[25]),
    .opField (instrWord[24:21]),
    .sBit    (instrWord[20]),
    .padBits (instrWord[11:4]),
    .strobes (strobes),
    .done    (done)
  );

  dpExecData #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .IMM_W  (IMM_W)
  ) data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .immField  (instrWord[IMM_W-1:0]),
    .rdField   (instrWord[15:12]),
    .rnData    (rdDataA),
    .rmData    (rdDataB),
    .statusIn  (statusIn),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .statusOut (statusOut)
  );

endmodule

// File: rtl/dpExecChecker.sv
module dpExecChecker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [31:0]       instrWord,
  input logic [DATA_W-1:0] statusIn,
  input logic              wrEn,
  input logic [DATA_W-1:0] statusOut,
  input logic              done
);

  localparam int FLAG_C = DATA_W - 3;
  localparam int FLAG_V = DATA_W - 4;

  logic isArithOp;
  assign isArithOp = (instrWord[24:21] inside {4'd2, 4'd3, 4'd4, 4'd5,
                                              4'd6, 4'd7, 4'd10, 4'd11});

  assert_done_follows_start_R12: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  assert_no_done_without_start_R12: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  assert_write_only_with_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> done);

  assert_mid_bits_pass_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (statusOut[FLAG_V-1:1] == $past(statusIn[FLAG_V-1:1])));

  assert_illegal_no_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && statusOut[0]) |-> !wrEn);

  assert_illegal_keeps_status_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && statusOut[0]) |-> (statusOut[DATA_W-1:1] == $past(statusIn[DATA_W-1:1])));

  assert_bad_top_is_illegal_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(instrWord[31:26] != 6'b111000)) |-> statusOut[0]);

  assert_compare_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(instrWord[24:23] == 2'b10)) |-> !wrEn);

  assert_logical_keeps_cv_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && !statusOut[0] && $past(!isArithOp)) |->
      (statusOut[FLAG_C] == $past(statusIn[FLAG_C]) &&
       statusOut[FLAG_V] == $past(statusIn[FLAG_V])));

endmodule

bind dpExecUnit dpExecChecker #(.DATA_W(DATA_W)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .instrWord (instrWord),
  .statusIn  (statusIn),
  .wrEn      (wrEn),
  .statusOut (statusOut),
  .done      (done)
);

// File: tb/dpExecUnit_test.sv
`timescale 1ns/1ps
module dpExecUnit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] statusIn = '0;
  logic [3:0]  rdSelA, rdSelB, wrSel;
  logic [31:0] rdDataA, rdDataB, wrData, statusOut;
  logic        wrEn, done;
  logic [31:0] regs [16];

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  assign rdDataA = regs[rdSelA];
  assign rdDataB = regs[rdSelB];

  dpExecUnit uut (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrWord),
    .statusIn(statusIn), .rdSelA(rdSelA), .rdSelB(rdSelB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .statusOut(statusOut), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic i, input logic [3:0] op, input logic s,
                                     input logic [3:0] rn, input logic [3:0] rd,
                                     input logic [7:0] low);
    return {6'b111000, i, op, s, rn, rd, 4'b0000, low};
  endfunction

  // Expected behaviour worked out from the requirements
  task automatic model(input logic [31:0] ins, input logic [31:0] st,
                       output logic expWr, output logic [31:0] expData,
                       output logic [31:0] expSt);
    logic        i, s, legal, arith, cmpOp, cf, cOut, vOut;
    logic [3:0]  op;
    logic [31:0] a, b, x, y, res;
    longint      sx, sy, sr;
    longint unsigned ux, uy, ur, extra;
    i  = ins[25];
    op = ins[24:21];
    s  = ins[20];
    a  = regs[ins[19:16]];
    b  = i ? {24'b0, ins[7:0]} : regs[ins[3:0]];
    cf = st[29];
    legal = (ins[31:26] == 6'b111000) &&
            (i ? (ins[11:8] == 4'b0) : (ins[11:4] == 8'b0));
    cmpOp = (op[3:2] == 2'b10);
    arith = 1'b1;
    cOut = 1'b0;
    vOut = 1'b0;
    res  = '0;
    x = a;
    y = b;
    extra = 0;
    case (op)
      4'd3, 4'd7: begin x = b; y = a; end
      default: ;
    endcase
    case (op)
      4'd2, 4'd3, 4'd10: extra = 0;
      4'd6, 4'd7:        extra = cf ? 0 : 1;
      4'd5:              extra = cf ? 1 : 0;
      default:           extra = 0;
    endcase
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    ux = x;
    uy = y;
    case (op)
      4'd2, 4'd3, 4'd6, 4'd7, 4'd10: begin
        sr   = sx - sy - longint'(extra);
        res  = sr[31:0];
        cOut = (ux >= uy + extra);
        vOut = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      4'd4, 4'd5, 4'd11: begin
        ur   = ux + uy + extra;
        sr   = sx + sy + longint'(extra);
        res  = ur[31:0];
        cOut = ur[32];
        vOut = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      default: begin
        arith = 1'b0;
        case (op)
          4'd0, 4'd8:  res = a & b;
          4'd1, 4'd9:  res = a ^ b;
          4'd12:       res = a | b;
          4'd13:       res = b;
          4'd14:       res = a & ~b;
          default:     res = ~b;
        endcase
      end
    endcase
    expData = res;
    expSt   = st;
    if (!legal) begin
      expWr    = 1'b0;
      expSt[0] = 1'b1;
    end else begin
      expWr    = !cmpOp;
      expSt[0] = 1'b0;
      if (s || cmpOp) begin
        expSt[31] = res[31];
        expSt[30] = (res == 32'b0);
        if (arith) begin
          expSt[29] = cOut;
          expSt[28] = vOut;
        end
      end
    end
  endtask

  task automatic execCheck(input string tag, input logic [31:0] ins, input logic [31:0] st);
    logic expWr;
    logic [31:0] expData, expSt;
    @(negedge clk);
    instrWord = ins;
    statusIn  = st;
    start     = 1'b1;
    model(ins, st, expWr, expData, expSt);
    @(negedge clk);
    start = 1'b0;
    chk({tag, " done"}, {31'b0, done}, 32'd1);
    chk({tag, " wrEn"}, {31'b0, wrEn}, {31'b0, expWr});
    if (expWr) begin
      chk({tag, " wrData"}, wrData, expData);
      chk({tag, " wrSel"}, {28'b0, wrSel}, {28'b0, ins[15:12]});
    end
    chk({tag, " status"}, statusOut, expSt);
  endtask

  task automatic testReset;
    chk("R12 reset done", {31'b0, done}, 32'd0);
    chk("R12 reset wrEn", {31'b0, wrEn}, 32'd0);
  endtask

  task automatic testSelects;
    @(negedge clk);
    instrWord = mk(1'b0, 4'd4, 1'b0, 4'd9, 4'd2, 8'h0C);
    #1;
    chk("R3 rdSelA", {28'b0, rdSelA}, 32'd9);
    chk("R3 rdSelB", {28'b0, rdSelB}, 32'd12);
    execCheck("R3 imm operand", mk(1'b1, 4'd4, 1'b0, 4'd1, 4'd3, 8'hAB), 32'h0);
    execCheck("R3 reg operand", mk(1'b0, 4'd4, 1'b0, 4'd1, 4'd8, 8'h02), 32'h0);
  endtask

  task automatic testIllegal;
    execCheck("R1 bad top", {6'b000000, mk(1'b0, 4'd4, 1'b1, 4'd1, 4'd2, 8'h02)} & 32'h03FF_FFFF, 32'hA000_0000);
    execCheck("R1 rotate bits", mk(1'b1, 4'd4, 1'b1, 4'd1, 4'd2, 8'h01) | 32'h0000_0100, 32'h5000_0000);
    execCheck("R1 shift bits", mk(1'b0, 4'd13, 1'b1, 4'd1, 4'd2, 8'h22), 32'hF000_0002);
    execCheck("R2 illegal keeps", mk(1'b0, 4'd4, 1'b1, 4'd1, 4'd2, 8'h02) | 32'h0000_0800, 32'h3000_00F0);
    execCheck("R2 legal clears", mk(1'b1, 4'd13, 1'b0, 4'd0, 4'd2, 8'h11), 32'h0000_0001);
  endtask

  task automatic testLogical;
    execCheck("R4 and", mk(1'b0, 4'd0, 1'b1, 4'd6, 4'd1, 8'h02), 32'h3000_0000);
    execCheck("R4 eor", mk(1'b0, 4'd1, 1'b1, 4'd6, 4'd1, 8'h04), 32'h0);
    execCheck("R4 orr", mk(1'b1, 4'd12, 1'b1, 4'd1, 4'd1, 8'h0F), 32'h0);
    execCheck("R4 bic", mk(1'b1, 4'd14, 1'b1, 4'd4, 4'd1, 8'hFF), 32'h0);
    execCheck("R4 mvn zero", mk(1'b0, 4'd15, 1'b1, 4'd0, 4'd1, 8'h04), 32'h2000_0000);
    execCheck("R11 logical keeps CV", mk(1'b0, 4'd0, 1'b1, 4'd4, 4'd1, 8'h05), 32'h3000_0000);
  endtask

  task automatic testArith;
    execCheck("R5 add", mk(1'b1, 4'd4, 1'b1, 4'd7, 4'd2, 8'h10), 32'h0);
    execCheck("R5 sub", mk(1'b1, 4'd2, 1'b1, 4'd7, 4'd2, 8'h09), 32'h0);
    execCheck("R5 rsb", mk(1'b1, 4'd3, 1'b1, 4'd7, 4'd2, 8'h09), 32'h0);
    execCheck("R10 add overflow", mk(1'b1, 4'd4, 1'b1, 4'd3, 4'd2, 8'h01), 32'h0);
    execCheck("R10 add carry", mk(1'b1, 4'd4, 1'b1, 4'd4, 4'd2, 8'h01), 32'h0);
    execCheck("R10 sub overflow", mk(1'b0, 4'd2, 1'b1, 4'd5, 4'd2, 8'h07), 32'h0);
    execCheck("R10 sub no borrow", mk(1'b0, 4'd2, 1'b1, 4'd7, 4'd2, 8'h07), 32'h0);
  endtask

  task automatic testCarryIn;
    execCheck("R6 adc C1", mk(1'b1, 4'd5, 1'b1, 4'd7, 4'd2, 8'h01), 32'h2000_0000);
    execCheck("R6 adc C0", mk(1'b1, 4'd5, 1'b1, 4'd7, 4'd2, 8'h01), 32'h0);
    execCheck("R6 sbc C0", mk(1'b1, 4'd6, 1'b1, 4'd7, 4'd2, 8'h05), 32'h0);
    execCheck("R6 sbc C1", mk(1'b1, 4'd6, 1'b1, 4'd7, 4'd2, 8'h05), 32'h2000_0000);
    execCheck("R6 rsc C0", mk(1'b1, 4'd7, 1'b1, 4'd7, 4'd2, 8'h05), 32'h0);
    execCheck("R6 rsc C1", mk(1'b1, 4'd7, 1'b1, 4'd7, 4'd2, 8'h09), 32'h2000_0000);
  endtask

  task automatic testCompare;
    execCheck("R7 cmp S0", mk(1'b1, 4'd10, 1'b0, 4'd7, 4'd2, 8'h05), 32'h0);
    execCheck("R7 cmn", mk(1'b0, 4'd11, 1'b0, 4'd4, 4'd2, 8'h07), 32'h0);
    execCheck("R7 tst", mk(1'b1, 4'd8, 1'b0, 4'd1, 4'd2, 8'h0F), 32'h1000_0000);
    execCheck("R7 teq", mk(1'b0, 4'd9, 1'b1, 4'd6, 4'd2, 8'h06), 32'h0);
  endtask

  task automatic testMovIgnoresRn;
    regs[9] = 32'hDEAD_BEEF;
    execCheck("R8 mov rn A", mk(1'b1, 4'd13, 1'b1, 4'd9, 4'd2, 8'h80), 32'h0);
    regs[9] = 32'h0000_0001;
    execCheck("R8 mov rn B", mk(1'b1, 4'd13, 1'b1, 4'd9, 4'd2, 8'h80), 32'h0);
    execCheck("R8 mvn rn B", mk(1'b0, 4'd15, 1'b1, 4'd9, 4'd2, 8'h06), 32'h0);
  endtask

  task automatic testFlagsS;
    execCheck("R9 S0 keeps flags", mk(1'b1, 4'd2, 1'b0, 4'd7, 4'd2, 8'h05), 32'hA000_0000);
    execCheck("R9 S1 zero", mk(1'b1, 4'd2, 1'b1, 4'd7, 4'd2, 8'h05), 32'h8000_0000);
    execCheck("R9 S1 negative", mk(1'b0, 4'd13, 1'b1, 4'd0, 4'd2, 8'h05), 32'h4000_0000);
  endtask

  task automatic testTiming;
    execCheck("R12 mid bits", mk(1'b1, 4'd4, 1'b1, 4'd7, 4'd2, 8'h01), 32'h0ABC_DEF0);
    @(negedge clk);
    chk("R12 done drops", {31'b0, done}, 32'd0);
    chk("R12 wrEn drops", {31'b0, wrEn}, 32'd0);
  endtask

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) regs[k] = 32'h0;
    regs[1] = 32'h0000_00F0;
    regs[2] = 32'h0000_0F0F;
    regs[3] = 32'h7FFF_FFFF;
    regs[4] = 32'hFFFF_FFFF;
    regs[5] = 32'h8000_0000;
    regs[6] = 32'h1234_5678;
    regs[7] = 32'h0000_0005;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSelects();
    testIllegal();
    testLogical();
    testArith();
    testCarryIn();
    testCompare();
    testMovIgnoresRn();
    testFlagsS();
    testTiming();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule